// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer with Fault Latch

This block is the synchronous control core of one half-bridge gate-driver channel. Each clock it takes an active-high high-side command, an active-high low-side command, the sampled level of a shared active-low shutdown line, a digitised overcurrent flag and a supply-undervoltage status bit. From these it produces the high-side and low-side gate enables and an enable for an open-drain transistor that pulls the shared shutdown line low.

Two state machines sit under the top. The phase machine (`hbd_phase_fsm`) has the states PH_OFF, PH_HI and PH_LO. It enters PH_HI or PH_LO from PH_OFF when exactly one command is present and the dead-time counter has expired. The counter may also be still running, as long as the side that last turned off is the side now requested. From PH_HI or PH_LO it returns to PH_OFF once its command goes away, and that transition reloads the counter. There is no direct transition between PH_HI and PH_LO.

The fault machine (`hbd_fault_fsm`) has the states FLT_RUN, FLT_HOLD and FLT_WAIT. An overcurrent trip moves it from FLT_RUN to FLT_HOLD, where it drives the pull-down. The sampled shutdown line reading low moves it from FLT_HOLD to FLT_WAIT. A high line moves it from FLT_WAIT back to FLT_RUN, and a trip moves it from FLT_WAIT back to FLT_HOLD. On top of the registered outputs, a trip gates both enables off combinationally, in the same cycle.

Top module: `hb_gate_ctrl`

## Requirements
- R1: When `sd_n_in` is low at a rising clock edge, both gate enables are low after that edge, whatever the commands are.
- R2: When both `cmd_hi` and `cmd_lo` are high at an edge, neither gate enable is high after that edge.
- R3: With no fault, no undervoltage and the dead time expired, a single high command drives only `gate_hi`. A single low command drives only `gate_lo`. No command drives neither. A change takes effect at the next edge.
- R4: After one gate enable falls, the opposite enable rises no earlier than DEAD_CYC cycles later, so both are low for at least DEAD_CYC sampled cycles. If the request is still present, it rises exactly then.
- R5: While `oc_trip` is high, both gate enables are low in the same cycle, without waiting for a clock edge.
- R6: A trip sampled at an edge sets `od_pull` high after that edge. It stays high until the edge at which `sd_n_in` is sampled low, and is low after that edge.
- R7: A trip that arrives while `od_pull` is already high changes nothing: the release still happens at the first edge with `sd_n_in` low.
- R8: After `od_pull` is released, both enables stay low until an edge samples `sd_n_in` high. Commands act from the edge after that one.
- R9: While `uv_flag` is high at an edge, both enables are low after that edge.
- R10: After reset, both enables and `od_pull` are low, and the dead time counts as already expired.
- R11: `gate_hi` and `gate_lo` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_hi | input | 1 | High-side command, active high |
| cmd_lo | input | 1 | Low-side command, active high |
| sd_n_in | input | 1 | Sampled shared shutdown line, low means shut down |
| oc_trip | input | 1 | Digitised overcurrent comparator flag |
| uv_flag | input | 1 | Supply undervoltage status, high means under |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |
| od_pull | output | 1 | Open-drain pull-down enable for the shutdown line |

## Verification
The bench is built with a three-cycle dead time. It measures the gap when a high-side command hands over straight to a low-side command; a counter that is off by one would show a gap of two or four cycles. It fires a trip in the middle of a cycle and samples the enables before the next edge, so a design that registers the trip path would leave a side on for one cycle. It fires a second trip during the hold, where a design that restarts or latches the hold would not release on the low line. It also brings the line back high after a release; a design that skips FLT_WAIT would drive the gate one cycle early. Sweeps with random input patterns, each command held for several different lengths, compare every cycle against a cycle model built from the requirements.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
    typedef enum logic [1:0] {
        FLT_RUN  = 2'd0,
        FLT_HOLD = 2'd1,
        FLT_WAIT = 2'd2
    } flt_state_t;

    typedef enum logic [1:0] {
        PH_OFF = 2'd0,
        PH_HI  = 2'd1,
        PH_LO  = 2'd2
    } phase_state_t;

    typedef enum logic {
        SIDE_HI = 1'b0,
        SIDE_LO = 1'b1
    } side_t;
endpackage

// File: rtl/hbd_fault_fsm.sv
module hbd_fault_fsm
    import hbd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic oc_trip,
    input  logic sd_n_in,
    output logic od_pull,
    output logic run_ok
);
    flt_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLT_RUN:  if (oc_trip) st_d = FLT_HOLD;
            FLT_HOLD: if (!sd_n_in) st_d = FLT_WAIT;
            FLT_WAIT: begin
                if (oc_trip)      st_d = FLT_HOLD;
                else if (sd_n_in) st_d = FLT_RUN;
            end
            default: st_d = FLT_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLT_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        od_pull = (st_q == FLT_HOLD);
        run_ok  = (st_q == FLT_RUN);
    end

    // R6: a trip outside the hold engages the pull-down at the next edge
    assert_trip_engages_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_trip && !od_pull) |=> od_pull);
    // R6 / R7: a low line always releases the pull-down, even with a trip present
    assert_low_line_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (od_pull && !sd_n_in) |=> !od_pull);
    // R8: leaving the hold never lands directly in the running state
    assert_wait_after_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        od_pull |=> !run_ok);
endmodule

// File: rtl/hbd_phase_fsm.sv
module hbd_phase_fsm
    import hbd_pkg::*;
#(
    parameter int DEAD_CYC = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic allow,
    input  logic cmd_hi,
    input  logic cmd_lo,
    output logic q_hi,
    output logic q_lo
);
    localparam int CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] RELOAD = CW'(DEAD_CYC - 1);

    phase_state_t ph_q, ph_d;
    logic [CW-1:0] cnt_q, cnt_d;
    side_t last_q, last_d;
    logic want_hi, want_lo, expired;

    always_comb begin
        want_hi = allow && cmd_hi && !cmd_lo;
        want_lo = allow && cmd_lo && !cmd_hi;
        expired = (cnt_q == '0);
    end

    always_comb begin
        ph_d   = ph_q;
        last_d = last_q;
        cnt_d  = expired ? cnt_q : cnt_q - 1'b1;
        unique case (ph_q)
            PH_OFF: begin
                if (want_hi && (expired || last_q == SIDE_HI))      ph_d = PH_HI;
                else if (want_lo && (expired || last_q == SIDE_LO)) ph_d = PH_LO;
            end
            PH_HI: if (!want_hi) begin
                ph_d = PH_OFF; cnt_d = RELOAD; last_d = SIDE_HI;
            end
            PH_LO: if (!want_lo) begin
                ph_d = PH_OFF; cnt_d = RELOAD; last_d = SIDE_LO;
            end
            default: ph_d = PH_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q   <= PH_OFF;
            cnt_q  <= '0;
            last_q <= SIDE_HI;
        end else begin
            ph_q   <= ph_d;
            cnt_q  <= cnt_d;
            last_q <= last_d;
        end
    end

    always_comb begin
        q_hi = (ph_q == PH_HI);
        q_lo = (ph_q == PH_LO);
    end

    // R4: the opposite side cannot follow on the edge after a turn-off
    assert_gap_hi_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q_hi) |-> !q_lo);
    assert_gap_lo_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q_lo) |-> !q_hi);
    // R2: contradictory commands never leave a side on
    assert_interlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hi && cmd_lo) |=> (!q_hi && !q_lo));
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl #(
    parameter int DEAD_CYC = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_hi,
    input  logic cmd_lo,
    input  logic sd_n_in,
    input  logic oc_trip,
    input  logic uv_flag,
    output logic gate_hi,
    output logic gate_lo,
    output logic od_pull
);
    logic run_ok, allow, q_hi, q_lo;

    hbd_fault_fsm u_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .oc_trip (oc_trip),
        .sd_n_in (sd_n_in),
        .od_pull (od_pull),
        .run_ok  (run_ok)
    );

    always_comb allow = run_ok && sd_n_in && !uv_flag && !oc_trip;

    hbd_phase_fsm #(.DEAD_CYC(DEAD_CYC)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .allow  (allow),
        .cmd_hi (cmd_hi),
        .cmd_lo (cmd_lo),
        .q_hi   (q_hi),
        .q_lo   (q_lo)
    );

    // fast path: a trip kills both sides without a clock edge
    always_comb begin
        gate_hi = q_hi && !oc_trip;
        gate_lo = q_lo && !oc_trip;
    end

    // R11: both sides never on together
    assert_no_shoot_through_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));
    // R1: a low shutdown line clears both sides at the next edge
    assert_shutdown_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_n_in |=> (!gate_hi && !gate_lo));
    // R9: undervoltage clears both sides at the next edge
    assert_uv_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |=> (!gate_hi && !gate_lo));
    // R8: while the pull-down is held no side is driven
    assert_hold_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        od_pull |-> (!gate_hi && !gate_lo));
endmodule

// File: tb/tb_hb_gate_ctrl.sv
module tb_hb_gate_ctrl;
    localparam int D = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_hi = 0, cmd_lo = 0, sd_n_in = 1, oc_trip = 0, uv_flag = 0;
    logic gate_hi, gate_lo, od_pull;

    hb_gate_ctrl #(.DEAD_CYC(D)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
        .sd_n_in(sd_n_in), .oc_trip(oc_trip), .uv_flag(uv_flag),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .od_pull(od_pull)
    );

    always #4 clk = ~clk;

    int n_run = 0, n_fail = 0;
    // cycle model: fault state 0 run, 1 hold, 2 wait; side 0 high, 1 low
    int m_st, m_gap, m_last;
    logic m_hi, m_lo;

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; cmd_hi = 0; cmd_lo = 0; sd_n_in = 1; oc_trip = 0; uv_flag = 0;
        m_st = 0; m_gap = D; m_last = 0; m_hi = 0; m_lo = 0;
        @(negedge clk);
        rst_n = 1;
    endtask

    // drive at negedge, check the model before the edge, advance at the edge
    task automatic step(input logic h, input logic l, input logic s, input logic o, input logic u);
        logic allow, wh, wl, n_hi, n_lo;
        int n_gap, n_last, n_st;
        @(negedge clk);
        cmd_hi = h; cmd_lo = l; sd_n_in = s; oc_trip = o; uv_flag = u;
        #1;
        chk(gate_hi === (m_hi && !o), "R3 R4 R5 model gate_hi", gate_hi, m_hi && !o);
        chk(gate_lo === (m_lo && !o), "R3 R4 R5 model gate_lo", gate_lo, m_lo && !o);
        chk(od_pull === (m_st == 1), "R6 R7 model od_pull", od_pull, m_st == 1);
        allow = (m_st == 0) && s && !u && !o;
        wh = allow && h && !l;
        wl = allow && l && !h;
        n_hi = m_hi; n_lo = m_lo; n_last = m_last;
        n_gap = (m_gap < D) ? m_gap + 1 : D;
        if (m_hi && !wh) begin
            n_hi = 0; n_gap = 1; n_last = 0;
        end else if (m_lo && !wl) begin
            n_lo = 0; n_gap = 1; n_last = 1;
        end else if (!m_hi && !m_lo) begin
            if (wh && (m_gap >= D || m_last == 0)) n_hi = 1;
            else if (wl && (m_gap >= D || m_last == 1)) n_lo = 1;
        end
        n_st = m_st;
        if (m_st == 0 && o) n_st = 1;
        else if (m_st == 1 && !s) n_st = 2;
        else if (m_st == 2) n_st = o ? 1 : (s ? 0 : 2);
        @(posedge clk);
        m_hi = n_hi; m_lo = n_lo; m_gap = n_gap; m_last = n_last; m_st = n_st;
    endtask

    initial begin
        #(200000 * 8);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [15:0] lf;
        int gap;
        lf = 16'hACE1;
        do_reset();
        #2;
        // R10: outputs idle after reset
        chk(gate_hi === 0 && gate_lo === 0, "R10 reset gates", {gate_hi, gate_lo}, 0);
        chk(od_pull === 0, "R10 reset od_pull", od_pull, 0);
        // R10: dead time expired, so first command acts at the first edge
        step(1, 0, 1, 0, 0);
        #2 chk(gate_hi === 1, "R10 R3 first command immediate", gate_hi, 1);
        repeat (3) step(1, 0, 1, 0, 0);
        // R4: hand over from high to low, count off cycles
        gap = 0;
        step(0, 1, 1, 0, 0);
        while (gap < 20) begin
            #2;
            if (gate_lo === 1) break;
            if (gate_hi === 0) gap++;
            step(0, 1, 1, 0, 0);
        end
        chk(gap == D, "R4 dead gap length", gap, D);
        // R2: both commands
        repeat (2) step(1, 1, 1, 0, 0);
        #2 chk(gate_hi === 0 && gate_lo === 0, "R2 interlock", {gate_hi, gate_lo}, 0);
        // R1: shutdown low with a valid command
        repeat (D + 2) step(0, 1, 1, 0, 0);
        step(0, 1, 0, 0, 0);
        #2 chk(gate_lo === 0, "R1 shutdown clears", gate_lo, 0);
        // R9: undervoltage
        repeat (D + 2) step(1, 0, 1, 0, 0);
        step(1, 0, 1, 0, 1);
        #2 chk(gate_hi === 0, "R9 undervoltage clears", gate_hi, 0);
        // R5: trip mid-cycle clears before any edge
        repeat (D + 2) step(1, 0, 1, 0, 0);
        @(negedge clk); oc_trip = 1; #1;
        chk(gate_hi === 0, "R5 immediate trip", gate_hi, 0);
        @(posedge clk); m_hi = 0; m_st = 1; m_gap = 1; m_last = 0;
        #2 chk(od_pull === 1, "R6 pull-down engaged", od_pull, 1);
        repeat (4) step(1, 0, 1, 0, 0);
        #2 chk(od_pull === 1, "R6 pull-down held while line high", od_pull, 1);
        step(1, 0, 1, 1, 0);
        #2 chk(od_pull === 1, "R7 second trip during hold", od_pull, 1);
        step(1, 0, 0, 0, 0);
        #2 chk(od_pull === 0, "R7 R6 release on low line", od_pull, 0);
        // R8: line returns high; gate acts one edge later
        step(1, 0, 1, 0, 0);
        #2 chk(gate_hi === 0, "R8 still off on return edge", gate_hi, 0);
        step(1, 0, 1, 0, 0);
        #2 chk(gate_hi === 1, "R8 command after return", gate_hi, 1);
        // sweeps with several command hold lengths
        foreach (lf[i]) begin end
        for (int k = 0; k < 4; k++) begin
            int hl;
            logic h, l;
            hl = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 5 : 9;
            h = 0; l = 0;
            do_reset();
            for (int c = 0; c < 600; c++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                if (c % hl == 0) begin h = lf[0]; l = lf[1]; end
                step(h, l, lf[6:3] != 0, lf[11:7] == 0, lf[15:12] == 4'hF && lf[2]);
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule